// File: doc/BRIEF.md
# Serial Program-Verify Command Engine

This block is the target side of a two-wire programming link. An external programmer drives a serial clock and a data line. It sends 6-bit commands, and some commands are followed by a 16-clock data frame. The engine runs on a fast system clock and synchronises both serial inputs. It finds the serial clock edges by comparing consecutive synchronised samples.

Decoded commands become single-cycle strobes toward the address counter and the non-volatile array: increment, program start, program stop and erase start. A load frame fills a 12-bit write register. A read frame sends a memory word back on the data line, under an output enable that is active only for the data slots of the frame.

Two busy inputs stand in for the real erase and write durations. Commands that arrive while a busy input is high are dropped and reported. A mode-enable input returns the framing logic to the start of a command.

Top module: `sprog_target`

## Requirements
- R1: A command is six serial clocks long. Each bit is taken on a falling serial clock edge, least significant bit first.
- R2: Only the low four command bits are decoded, as 4'h2 load, 4'h4 read, 4'h6 increment, 4'h8 begin write, 4'hE end write and 4'h9 bulk erase. The two upper bits have no effect. Any other code produces no strobe and no error.
- R3: An accepted increment pulses `addr_incr` and an accepted bulk erase pulses `erase_start`. At most one of the five strobes (`addr_incr`, `load_strobe`, `prog_start`, `prog_stop`, `erase_start`) is high in any cycle.
- R4: Load and read are each followed by a 16-clock frame. Slot 0 is the start slot and slot 15 is the stop slot, and their data values are ignored. Slots 1 to 14 carry a 14-bit word, least significant bit first, taken on falling edges. For a load, slots 13 and 14 are dropped. On the falling edge of the stop slot, `load_word` takes word bits 11:0 and `load_strobe` pulses.
- R5: A read samples `mem_rdata` when its command completes. `ser_dat_oe` rises on the 2nd rising serial clock of the frame and falls on the 16th. On rising edge k (for k from 2 to 15), `ser_dat_out` carries word bit k-2, and word bits 13:12 are sent as 0.
- R6: A begin-write command that has had a load since the previous begin pulses `prog_start` and raises `prog_active`. `prog_active` stays high until an end-write command, which pulses `prog_stop` and lowers `prog_active`.
- R7: A begin-write command with no load since the previous begin pulses `seq_err` and does not pulse `prog_start`.
- R8: While `erase_busy` is high, every command is dropped. While `prog_busy` is high, every command except end-write is dropped. A dropped command pulses `busy_err` and produces no strobe. A dropped load or read still consumes its 16-clock frame, but it neither updates `load_word` nor drives the data line.
- R9: While `mode_en` is low, the engine returns to the first bit of a command, clears the load-seen and write-active state, and releases the data line.
- R10: Each strobe or error pulse is high for one system cycle. It rises on the third rising system clock edge after the serial clock edge that completes its command or frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Program-verify mode active; low holds the framing logic at command start |
| ser_clk | input | 1 | Serial clock from the programmer |
| ser_dat_in | input | 1 | Serial data input |
| ser_dat_out | output | 1 | Serial data output during read frames |
| ser_dat_oe | output | 1 | Output enable for the data line |
| mem_rdata | input | 12 | Word at the current address, for reads |
| erase_busy | input | 1 | Erase in progress |
| prog_busy | input | 1 | Write in progress |
| addr_incr | output | 1 | Increment-address strobe |
| load_strobe | output | 1 | Load frame accepted |
| load_word | output | 12 | Last accepted load data |
| prog_start | output | 1 | Begin-write strobe |
| prog_stop | output | 1 | End-write strobe |
| prog_active | output | 1 | Write cycle open |
| erase_start | output | 1 | Bulk-erase strobe |
| seq_err | output | 1 | Begin-write with no preceding load |
| busy_err | output | 1 | Command dropped because of busy |

## Verification
A serial edge passes through two synchroniser flops and one edge-compare stage before the result is registered. Every strobe, error pulse, `load_word` update and change on the data line therefore appears three system cycles after the serial edge that causes it. The bench changes inputs on falling system clock edges and holds each serial level for eight system cycles. Read data and the output enable are sampled five cycles after each rising serial edge, well inside the settled window. Strobes are counted on every rising system clock edge and compared per scenario. One directed check samples the increment strobe at cycles two, three and four after the final falling edge, which pins the exact latency and the one-cycle width.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int CMD_W      = 6;
  localparam int KEY_W      = 4;
  localparam int WORD_W     = 14;
  localparam int LOAD_W     = 12;
  localparam int FRAME_CLKS = 16;

  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_READ, K_INCR, K_BEGIN, K_END, K_ERASE
  } cmd_kind_t;

  typedef enum logic { PH_CMD, PH_DATA } phase_t;

  // low nibble of a received command selects its action
  function automatic cmd_kind_t decode_cmd(input logic [KEY_W-1:0] key);
    case (key)
      4'h2:    return K_LOAD;
      4'h4:    return K_READ;
      4'h6:    return K_INCR;
      4'h8:    return K_BEGIN;
      4'hE:    return K_END;
      4'h9:    return K_ERASE;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic has_frame(input cmd_kind_t k);
    return (k == K_LOAD) || (k == K_READ);
  endfunction

  // a command is dropped under erase, or under write unless it ends the write
  function automatic logic cmd_accepted(input cmd_kind_t k, input logic ebusy,
                                        input logic pbusy);
    return !(ebusy || (pbusy && (k != K_END)));
  endfunction
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] dt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '0;
    end else begin
      ck_q <= {ck_q[STAGES-1:0], sclk_i};
      dt_q <= {dt_q[STAGES-2:0], sdat_i};
    end
  end

  assign sclk_rise = ck_q[STAGES-1] & ~ck_q[STAGES];
  assign sclk_fall = ~ck_q[STAGES-1] & ck_q[STAGES];
  assign din       = dt_q[STAGES-1];
endmodule

// File: rtl/sprog_framer.sv
module sprog_framer
  import sprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din,
  input  logic              accept,
  input  logic [LOAD_W-1:0] mem_rdata,
  output logic              cmd_done,
  output logic [KEY_W-1:0]  cmd_key,
  output logic              load_strobe,
  output logic [LOAD_W-1:0] load_word,
  output logic              dat_out,
  output logic              dat_oe
);
  localparam int CC_W = $clog2(CMD_W);
  localparam int DC_W = $clog2(FRAME_CLKS);
  localparam logic [CC_W-1:0] CMD_LAST  = CC_W'(CMD_W - 1);
  localparam logic [DC_W-1:0] SLOT_STOP = DC_W'(FRAME_CLKS - 1);
  localparam logic [DC_W-1:0] SLOT_LOAD = DC_W'(LOAD_W);
  localparam logic [DC_W-1:0] SLOT_WORD = DC_W'(WORD_W);

  phase_t            phase;
  logic [CC_W-1:0]   cmd_cnt;
  logic [DC_W-1:0]   dat_cnt;
  logic [CMD_W-2:0]  csr;
  logic              live, rd_frame;
  logic [LOAD_W-1:0] rx, tx;
  cmd_kind_t         kind;

  assign cmd_done = sclk_fall && (phase == PH_CMD) && (cmd_cnt == CMD_LAST);
  assign cmd_key  = csr[KEY_W-1:0];
  assign kind     = decode_cmd(cmd_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; cmd_cnt <= '0; dat_cnt <= '0; csr <= '0;
      live <= 1'b0; rd_frame <= 1'b0; rx <= '0; tx <= '0;
      load_strobe <= 1'b0; load_word <= '0; dat_out <= 1'b0; dat_oe <= 1'b0;
    end else if (!mode_en) begin
      phase <= PH_CMD; cmd_cnt <= '0; dat_cnt <= '0;
      live <= 1'b0; rd_frame <= 1'b0; load_strobe <= 1'b0;
      dat_out <= 1'b0; dat_oe <= 1'b0;
    end else begin
      load_strobe <= 1'b0;
      if (phase == PH_CMD) begin
        if (sclk_fall) begin
          if (cmd_cnt == CMD_LAST) begin
            cmd_cnt <= '0;
            if (has_frame(kind)) begin
              phase    <= PH_DATA;
              dat_cnt  <= '0;
              live     <= accept;
              rd_frame <= (kind == K_READ);
              if (kind == K_READ) tx <= mem_rdata;
            end
          end else begin
            csr     <= {din, csr[CMD_W-2:1]};
            cmd_cnt <= cmd_cnt + 1'b1;
          end
        end
      end else begin
        if (sclk_fall) begin
          if (dat_cnt >= 1 && dat_cnt <= SLOT_LOAD) rx <= {din, rx[LOAD_W-1:1]};
          if (dat_cnt == SLOT_STOP) begin
            phase   <= PH_CMD;
            dat_cnt <= '0;
            if (live && !rd_frame) begin
              load_word   <= rx;
              load_strobe <= 1'b1;
            end
          end else begin
            dat_cnt <= dat_cnt + 1'b1;
          end
        end
        if (sclk_rise && live && rd_frame) begin
          if (dat_cnt == 1)         dat_oe <= 1'b1;
          if (dat_cnt == SLOT_STOP) dat_oe <= 1'b0;
          if (dat_cnt >= 1 && dat_cnt <= SLOT_WORD) begin
            dat_out <= (dat_cnt <= SLOT_LOAD) ? tx[0] : 1'b0;
            tx      <= tx >> 1;
          end
        end
      end
    end
  end

  AST_CMD_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cnt <= CMD_LAST); // R1
  AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> (phase == PH_DATA) && rd_frame); // R5
  AST_OE_ON_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> $past(sclk_rise)); // R5
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (phase == PH_CMD) && (cmd_cnt == '0) && !dat_oe); // R9
endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              ser_clk,
  input  logic              ser_dat_in,
  output logic              ser_dat_out,
  output logic              ser_dat_oe,
  input  logic [LOAD_W-1:0] mem_rdata,
  input  logic              erase_busy,
  input  logic              prog_busy,
  output logic              addr_incr,
  output logic              load_strobe,
  output logic [LOAD_W-1:0] load_word,
  output logic              prog_start,
  output logic              prog_stop,
  output logic              prog_active,
  output logic              erase_start,
  output logic              seq_err,
  output logic              busy_err
);
  logic             sclk_rise, sclk_fall, din;
  logic             cmd_done, accept, load_seen;
  logic [KEY_W-1:0] cmd_key;
  cmd_kind_t        kind;

  sprog_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(ser_clk), .sdat_i(ser_dat_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din)
  );

  assign kind   = decode_cmd(cmd_key);
  assign accept = cmd_accepted(kind, erase_busy, prog_busy);

  sprog_framer u_framer (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din),
    .accept(accept), .mem_rdata(mem_rdata),
    .cmd_done(cmd_done), .cmd_key(cmd_key),
    .load_strobe(load_strobe), .load_word(load_word),
    .dat_out(ser_dat_out), .dat_oe(ser_dat_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_incr <= 1'b0; prog_start <= 1'b0; prog_stop <= 1'b0;
      erase_start <= 1'b0; seq_err <= 1'b0; busy_err <= 1'b0;
      prog_active <= 1'b0; load_seen <= 1'b0;
    end else if (!mode_en) begin
      addr_incr <= 1'b0; prog_start <= 1'b0; prog_stop <= 1'b0;
      erase_start <= 1'b0; seq_err <= 1'b0; busy_err <= 1'b0;
      prog_active <= 1'b0; load_seen <= 1'b0;
    end else begin
      addr_incr <= 1'b0; prog_start <= 1'b0; prog_stop <= 1'b0;
      erase_start <= 1'b0; seq_err <= 1'b0; busy_err <= 1'b0;
      if (load_strobe) load_seen <= 1'b1;
      if (cmd_done) begin
        if (!accept) begin
          busy_err <= 1'b1;
        end else begin
          case (kind)
            K_INCR:  addr_incr   <= 1'b1;
            K_ERASE: erase_start <= 1'b1;
            K_BEGIN: begin
              if (load_seen) begin
                prog_start  <= 1'b1;
                prog_active <= 1'b1;
                load_seen   <= 1'b0;
              end else begin
                seq_err <= 1'b1;
              end
            end
            K_END: begin
              prog_stop   <= 1'b1;
              prog_active <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_incr, load_strobe, prog_start, prog_stop, erase_start})); // R3
  AST_BEGIN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(load_seen)); // R6
  AST_WRITE_CLOSED_BY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_active) && $past(mode_en) |-> prog_stop); // R6
  AST_NO_START_ON_SEQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !prog_start && !prog_active); // R7
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> !(addr_incr || prog_start || erase_start)); // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_incr |=> !addr_incr); // R10
endmodule

// File: tb/tb_sprog_target.sv
`timescale 1ns/1ps
module tb_sprog_target;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0, mode_en = 0, ser_clk = 0, ser_dat_in = 0;
  logic [11:0] mem_rdata = 12'hA5C;
  logic erase_busy = 0, prog_busy = 0;
  logic ser_dat_out, ser_dat_oe, addr_incr, load_strobe, prog_start, prog_stop;
  logic prog_active, erase_start, seq_err, busy_err;
  logic [11:0] load_word;

  int checks = 0, errors = 0;
  int n_incr = 0, n_load = 0, n_pstart = 0, n_pstop = 0, n_erase = 0, n_seq = 0, n_busy = 0;
  int b_incr, b_load, b_pstart, b_pstop, b_erase, b_seq, b_busy;
  bit done = 0;

  always #5 clk = ~clk;

  sprog_target dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .ser_clk(ser_clk),
    .ser_dat_in(ser_dat_in), .ser_dat_out(ser_dat_out), .ser_dat_oe(ser_dat_oe),
    .mem_rdata(mem_rdata), .erase_busy(erase_busy), .prog_busy(prog_busy),
    .addr_incr(addr_incr), .load_strobe(load_strobe), .load_word(load_word),
    .prog_start(prog_start), .prog_stop(prog_stop), .prog_active(prog_active),
    .erase_start(erase_start), .seq_err(seq_err), .busy_err(busy_err)
  );

  always @(posedge clk) begin
    if (addr_incr)   n_incr++;
    if (load_strobe) n_load++;
    if (prog_start)  n_pstart++;
    if (prog_stop)   n_pstop++;
    if (erase_start) n_erase++;
    if (seq_err)     n_seq++;
    if (busy_err)    n_busy++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    b_incr = n_incr; b_load = n_load; b_pstart = n_pstart; b_pstop = n_pstop;
    b_erase = n_erase; b_seq = n_seq; b_busy = n_busy;
  endtask

  task automatic sbit(logic b);
    ser_dat_in = b; ser_clk = 1; tick(HP); ser_clk = 0; tick(HP);
  endtask

  task automatic send_cmd(logic [5:0] c);
    for (int i = 0; i < 6; i++) sbit(c[i]);
    tick(4);
  endtask

  task automatic send_load(logic [13:0] w, logic st, logic sp);
    send_cmd(6'h02);
    sbit(st);
    for (int i = 0; i < 14; i++) sbit(w[i]);
    sbit(sp);
    tick(4);
  endtask

  task automatic t_reset();
    check("R9 reset oe", ser_dat_oe, 0);
    check("R9 reset active", prog_active, 0);
    check("R9 reset load_word", load_word, 0);
  endtask

  task automatic t_latency();
    for (int i = 0; i < 5; i++) sbit(6'h06 >> i);
    ser_dat_in = 0; ser_clk = 1; tick(HP); ser_clk = 0;
    tick(2); check("R10 incr not yet", addr_incr, 0);
    tick(1); check("R10 incr at third cycle", addr_incr, 1);
    tick(1); check("R10 incr one cycle wide", addr_incr, 0);
    tick(6);
  endtask

  task automatic t_decode();
    snap(); send_cmd(6'h36);
    check("R2 upper bits ignored incr", n_incr - b_incr, 1);
    snap(); send_cmd(6'h05); send_cmd(6'h0F);
    check("R2 unknown no strobe", (n_incr-b_incr)+(n_erase-b_erase)+(n_pstop-b_pstop)+(n_seq-b_seq), 0);
    snap(); send_cmd(6'h09);
    check("R3 erase strobe", n_erase - b_erase, 1);
    check("R1 erase only", n_incr - b_incr, 0);
  endtask

  task automatic t_load();
    snap(); send_load(14'h3ABC, 1'b1, 1'b1);
    check("R4 load word drops top bits", load_word, 12'hABC);
    check("R4 load strobe", n_load - b_load, 1);
    send_load(14'h0123, 1'b1, 1'b0);
    check("R4 second load", load_word, 12'h123);
  endtask

  task automatic t_prog();
    snap(); send_cmd(6'h08);
    check("R6 begin after load", n_pstart - b_pstart, 1);
    check("R6 active", prog_active, 1);
    send_cmd(6'h0E);
    check("R6 end strobe", n_pstop - b_pstop, 1);
    check("R6 inactive", prog_active, 0);
    snap(); send_cmd(6'h08);
    check("R7 seq err", n_seq - b_seq, 1);
    check("R7 no start", n_pstart - b_pstart, 0);
    check("R7 not active", prog_active, 0);
  endtask

  task automatic t_read();
    logic [13:0] got = '0;
    logic [13:0] exp = {2'b00, mem_rdata};
    send_cmd(6'h04);
    for (int k = 0; k < 16; k++) begin
      ser_dat_in = 0; ser_clk = 1; tick(5);
      check($sformatf("R5 oe slot %0d", k), ser_dat_oe, (k >= 1 && k <= 14) ? 1 : 0);
      if (k >= 1 && k <= 14) got[k-1] = ser_dat_out;
      tick(HP - 5); ser_clk = 0; tick(HP);
    end
    check("R5 read word", got, exp);
    tick(4);
  endtask

  task automatic t_busy();
    erase_busy = 1; snap();
    send_cmd(6'h06);
    check("R8 incr dropped", n_incr - b_incr, 0);
    check("R8 busy err", n_busy - b_busy, 1);
    send_load(14'h0777, 1'b0, 1'b0);
    check("R8 load dropped", load_word, 12'h123);
    erase_busy = 0; snap();
    send_cmd(6'h06);
    check("R8 framing kept", n_incr - b_incr, 1);
    send_load(14'h0456, 1'b0, 1'b0);
    send_cmd(6'h08);
    prog_busy = 1; snap();
    send_cmd(6'h06);
    check("R8 incr dropped in write", n_incr - b_incr, 0);
    send_cmd(6'h0E);
    check("R8 end accepted in write", n_pstop - b_pstop, 1);
    check("R8 err count", n_busy - b_busy, 1);
    prog_busy = 0;
  endtask

  task automatic t_mode();
    send_load(14'h0111, 1'b0, 1'b0);
    send_cmd(6'h08);
    check("R9 active before exit", prog_active, 1);
    sbit(1'b0); sbit(1'b1); sbit(1'b1);
    mode_en = 0; tick(3);
    check("R9 active cleared", prog_active, 0);
    mode_en = 1; tick(2); snap();
    send_cmd(6'h06);
    check("R9 command restarts", n_incr - b_incr, 1);
    snap(); send_cmd(6'h08);
    check("R9 load-seen cleared", n_seq - b_seq, 1);
  endtask

  initial begin
    tick(3); rst_n = 1; tick(2);
    t_reset();
    mode_en = 1; tick(2);
    t_latency();
    t_decode();
    t_load();
    t_prog();
    t_read();
    t_busy();
    t_mode();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule